// File: doc/BRIEF.md
# Control-Line Encoded Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit for a small accumulator-style datapath. It takes two operands, `a_in` and `b_in`, and a carry flag from outside. Six independent control lines select its behaviour. It returns a result word, a zero indication and a carry-out. Any flag registers or result write-back belong to the surrounding datapath; this block only computes values.

The control lines are split into three groups. One line chooses whether the adder sees `b_in` or its bitwise complement. Two lines choose the adder's carry-in: the external flag, a forced one, or a forced zero. A three-bit selector then picks one of four logic results or the adder sum as the output. Subtraction is not a separate operation. The microcode sets both the complement line and the forced-one line together, which gives `a + ~b + 1`. Because those two lines are independent, other combinations are also available, such as increment, decrement-style sums and add-with-borrow.

Top module: `alu8_core`

## Requirements
- R1: When `inv_b` is 0 the adder receives `b_in` unchanged. When `inv_b` is 1 it receives the bitwise complement of `b_in`.
- R2: The adder carry-in is set by `{cin_one, cin_zero}`: 00 passes `carry_flag`, 10 forces 1, 01 forces 0, and 11 also forces 0.
- R3: With `inv_b`=1, `{cin_one,cin_zero}`=10 and the adder selected, `result` equals `a_in - b_in` modulo 256, and `carry_out` is 1 exactly when `a_in >= b_in`.
- R4: `op_sel` (bit 2 is the first select line) selects a logic result: 3'b000 gives `a_in & b_in`, 3'b100 gives `a_in | b_in`, 3'b010 gives `a_in ^ b_in`, and 3'b110 gives `~b_in`.
- R5: `op_sel` = 3'b001 makes `result` the low 8 bits of the adder sum.
- R6: The codes `op_sel` = 3'b011, 3'b101 and 3'b111 make `result` zero.
- R7: `zero_flag` is 1 exactly when `result` is all zeros, whatever `op_sel` is.
- R8: `carry_out` is the ninth bit of the adder sum when `op_sel` = 3'b001, and 0 for every other select code.
- R9: With every input at zero, the outputs are `result`=0, `zero_flag`=1 and `carry_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | First operand |
| b_in | input | 8 | Second operand; can be complemented before the adder |
| carry_flag | input | 1 | External carry flag, used as carry-in when not forced |
| inv_b | input | 1 | Feed the complement of `b_in` to the adder |
| cin_one | input | 1 | Force adder carry-in to 1 |
| cin_zero | input | 1 | Force adder carry-in to 0 (takes priority) |
| op_sel | input | 3 | Result select code |
| result | output | 8 | Selected result |
| zero_flag | output | 1 | High when `result` is zero |
| carry_out | output | 1 | Adder carry-out, 0 for logic operations |

## Verification
The bench targets the carry-in controls where both lines are high. A design that let the forced-one line win there would show a sum that is one too large. It drives subtraction with the operands in both orders, so a carry that is inverted or taken from the wrong bit shows up as the wrong borrow indication. Logic operations are run on operands whose sum would overflow, so a carry that leaks into logic results is caught. The three spare select codes are driven with all-ones operands, which exposes a decoder that falls through to some other operation. A sweep over every control combination compares the outputs with a model built from the requirements, which also catches swapped select bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned ALU_W = 8;
  localparam int unsigned SEL_W = 3;

  // Result select codes: bit 2 is the first select line.
  localparam logic [SEL_W-1:0] SEL_AND  = 3'b000;
  localparam logic [SEL_W-1:0] SEL_OR   = 3'b100;
  localparam logic [SEL_W-1:0] SEL_XOR  = 3'b010;
  localparam logic [SEL_W-1:0] SEL_NOTB = 3'b110;
  localparam logic [SEL_W-1:0] SEL_ADD  = 3'b001;

  typedef enum logic [1:0] {
    CIN_FLAG = 2'b00,
    CIN_ZERO = 2'b01,
    CIN_ONE  = 2'b10,
    CIN_BOTH = 2'b11
  } cin_ctl_e;
endpackage

// File: rtl/alu8_operand.sv
module alu8_operand #(
  parameter int unsigned W = alu8_pkg::ALU_W
) (
  input  logic [W-1:0] b_raw,
  input  logic         invert,
  input  logic         carry_flag,
  input  logic         force_one,
  input  logic         force_zero,
  output logic [W-1:0] b_eff,
  output logic         cin
);
  import alu8_pkg::*;

  cin_ctl_e cin_ctl;

  always_comb begin
    b_eff = invert ? ~b_raw : b_raw;
  end

  always_comb begin
    cin_ctl = cin_ctl_e'({force_one, force_zero});
    unique case (cin_ctl)
      CIN_FLAG: cin = carry_flag;
      CIN_ONE:  cin = 1'b1;
      CIN_ZERO: cin = 1'b0;
      CIN_BOTH: cin = 1'b0;
      default:  cin = 1'b0;
    endcase
  end

  always_comb begin
    // R2
    cin_both_chk: assert (!(force_one && force_zero) || (cin == 1'b0))
      else $error("carry-in not zero with both force lines high");
  end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int unsigned W = alu8_pkg::ALU_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end

  assign cout = carry[W];

  always_comb begin
    // R5
    ripple_sum_chk: assert ({cout, sum} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin}))
      else $error("ripple chain disagrees with arithmetic sum");
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int unsigned W = alu8_pkg::ALU_W
) (
  input  logic [W-1:0]                  a,
  input  logic [W-1:0]                  b,
  input  logic [alu8_pkg::SEL_W-1:0]    sel,
  output logic [W-1:0]                  y,
  output logic                          hit
);
  import alu8_pkg::*;

  always_comb begin
    hit = 1'b1;
    unique case (sel)
      SEL_AND:  y = a & b;
      SEL_OR:   y = a | b;
      SEL_XOR:  y = a ^ b;
      SEL_NOTB: y = ~b;
      default: begin
        y   = '0;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int unsigned W = alu8_pkg::ALU_W
) (
  input  logic [W-1:0]               a_in,
  input  logic [W-1:0]               b_in,
  input  logic                       carry_flag,
  input  logic                       inv_b,
  input  logic                       cin_one,
  input  logic                       cin_zero,
  input  logic [alu8_pkg::SEL_W-1:0] op_sel,
  output logic [W-1:0]               result,
  output logic                       zero_flag,
  output logic                       carry_out
);
  import alu8_pkg::*;

  logic [W-1:0] b_eff;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] logic_y;
  logic         logic_hit;
  logic         sel_add;

  alu8_operand #(.W(W)) u_operand (
    .b_raw      (b_in),
    .invert     (inv_b),
    .carry_flag (carry_flag),
    .force_one  (cin_one),
    .force_zero (cin_zero),
    .b_eff      (b_eff),
    .cin        (add_cin)
  );

  alu8_adder #(.W(W)) u_adder (
    .x    (a_in),
    .y    (b_eff),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout)
  );

  alu8_logic #(.W(W)) u_logic (
    .a   (a_in),
    .b   (b_in),
    .sel (op_sel),
    .y   (logic_y),
    .hit (logic_hit)
  );

  assign sel_add = (op_sel == SEL_ADD);

  always_comb begin
    if (sel_add) begin
      result    = add_sum;
      carry_out = add_cout;
    end else begin
      result    = logic_hit ? logic_y : '0;
      carry_out = 1'b0;
    end
    zero_flag = ~|result;
  end

  always_comb begin
    // R3
    sub_diff_chk: assert (!(sel_add && inv_b && cin_one && !cin_zero) ||
                          ((result == W'(a_in - b_in)) && (carry_out == (a_in >= b_in))))
      else $error("subtraction result or borrow wrong");
    // R6
    spare_code_chk: assert (!(op_sel == 3'b011 || op_sel == 3'b101 || op_sel == 3'b111) ||
                            (result == '0 && zero_flag))
      else $error("spare select code produced a nonzero result");
    // R8
    logic_carry_chk: assert (sel_add || !carry_out)
      else $error("carry-out raised for a logic operation");
    // R4
    not_b_chk: assert (op_sel != SEL_NOTB || (result ^ b_in) == '1)
      else $error("complement select wrong");
    // R1
    pass_b_chk: assert (!(sel_add && !inv_b && cin_zero) || result == W'(a_in + b_in))
      else $error("plain add wrong with carry-in forced low");
  end
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  logic       clk;
  logic [7:0] a_in, b_in, result;
  logic       carry_flag, inv_b, cin_one, cin_zero, zero_flag, carry_out;
  logic [2:0] op_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu8_core u_alu8_core (
    .a_in(a_in), .b_in(b_in), .carry_flag(carry_flag), .inv_b(inv_b),
    .cin_one(cin_one), .cin_zero(cin_zero), .op_sel(op_sel),
    .result(result), .zero_flag(zero_flag), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Fields: a, b, carry_flag, inv_b, cin_one, cin_zero, op_sel, exp result, exp zero, exp carry
  localparam int NV = 20;
  localparam logic [32:0] VEC [NV] = '{
    {8'h0F, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h0C, 1'b0, 1'b0}, // R4 and
    {8'h0F, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100, 8'h3F, 1'b0, 1'b0}, // R4 or
    {8'h0F, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 8'h33, 1'b0, 1'b0}, // R4 xor
    {8'h0F, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 3'b110, 8'hC3, 1'b0, 1'b0}, // R4 not b
    {8'h10, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 3'b001, 8'h33, 1'b0, 1'b0}, // R2 flag cin, R5
    {8'hFF, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 3'b001, 8'h00, 1'b1, 1'b1}, // R2 forced 0, R7, R8
    {8'h05, 8'h03, 1'b0, 1'b1, 1'b1, 1'b0, 3'b001, 8'h02, 1'b0, 1'b1}, // R3 no borrow
    {8'h03, 8'h05, 1'b0, 1'b1, 1'b1, 1'b0, 3'b001, 8'hFE, 1'b0, 1'b0}, // R3 borrow
    {8'h01, 8'h01, 1'b1, 1'b0, 1'b1, 1'b1, 3'b001, 8'h02, 1'b0, 1'b0}, // R2 both high
    {8'h05, 8'h03, 1'b0, 1'b1, 1'b0, 1'b1, 3'b001, 8'h01, 1'b0, 1'b1}, // R1 invert only
    {8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 3'b011, 8'h00, 1'b1, 1'b0}, // R6
    {8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 8'h00, 1'b1, 1'b0}, // R6
    {8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 3'b111, 8'h00, 1'b1, 1'b0}, // R6
    {8'hF0, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00, 1'b1, 1'b0}, // R7 logic zero
    {8'h7F, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 8'h80, 1'b0, 1'b0}, // R2 forced 1
    {8'hAA, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 8'h00, 1'b1, 1'b0}, // R7 xor equal
    {8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 3'b001, 8'h01, 1'b0, 1'b0}, // R1 inverted, flag cin
    {8'hFF, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h01, 1'b0, 1'b0}, // R8 logic no carry
    {8'h80, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 8'h00, 1'b1, 1'b1}, // R8 overflow, R7
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00, 1'b1, 1'b0}  // R9
  };

  function automatic logic [9:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic cf, input logic inv,
                                       input logic one, input logic zro,
                                       input logic [2:0] sel);
    logic [7:0] bb, r;
    logic       ci, co;
    logic [8:0] s;
    bb = inv ? ~b : b;
    ci = zro ? 1'b0 : (one ? 1'b1 : cf);
    s  = {1'b0, a} + {1'b0, bb} + {8'd0, ci};
    co = 1'b0;
    case (sel)
      3'b000: r = a & b;
      3'b100: r = a | b;
      3'b010: r = a ^ b;
      3'b110: r = ~b;
      3'b001: begin r = s[7:0]; co = s[8]; end
      default: r = 8'h00;
    endcase
    return {r, (r == 8'h00), co};
  endfunction

  task automatic check(input string req, input logic [9:0] exp);
    checks++;
    if ({result, zero_flag, carry_out} !== exp) begin
      fails++;
      $display("FAIL %s: a=%h b=%h sel=%b got res=%h z=%b c=%b exp res=%h z=%b c=%b",
               req, a_in, b_in, op_sel, result, zero_flag, carry_out,
               exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic cf,
                       input logic inv, input logic one, input logic zro,
                       input logic [2:0] sel);
    @(posedge clk);
    a_in = a; b_in = b; carry_flag = cf; inv_b = inv;
    cin_one = one; cin_zero = zro; op_sel = sel;
    @(negedge clk);
  endtask

  initial begin
    a_in = '0; b_in = '0; carry_flag = 0; inv_b = 0;
    cin_one = 0; cin_zero = 0; op_sel = '0;
    @(negedge clk);
    // R9: idle inputs
    check("R9", {8'h00, 1'b1, 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][32:25], VEC[i][24:17], VEC[i][16], VEC[i][15],
            VEC[i][14], VEC[i][13], VEC[i][12:10]);
      check("R1-table R2 R3 R4 R5 R6 R7 R8", VEC[i][9:0]);
    end

    // Directed sweep over every control combination
    for (int p = 0; p < 4; p++) begin
      logic [7:0] pa, pb;
      case (p)
        0: begin pa = 8'h5A; pb = 8'hA5; end
        1: begin pa = 8'hFF; pb = 8'h00; end
        2: begin pa = 8'h01; pb = 8'hFF; end
        default: begin pa = 8'h3C; pb = 8'h3C; end
      endcase
      for (int s = 0; s < 8; s++) begin
        for (int c = 0; c < 16; c++) begin
          apply(pa, pb, c[0], c[1], c[2], c[3], 3'(s));
          check("R2 R4 R5 R6 R7 R8 sweep",
                model(pa, pb, c[0], c[1], c[2], c[3], 3'(s)));
        end
      end
    end

    // R3: subtraction over a spread of operand pairs
    for (int k = 0; k < 32; k++) begin
      logic [7:0] xa, xb;
      xa = 8'(k * 37 + 11);
      xb = 8'(k * 53 + 200);
      apply(xa, xb, k[0], 1'b1, 1'b1, 1'b0, 3'b001);
      check("R3", {8'(xa - xb), (8'(xa - xb) == 8'h00), (xa >= xb)});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 20000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule